// File: doc/BRIEF.md
# Cycle counter with prescaler

This block is a free-running cycle counter with a configurable width, 64 bits by default. It advances by one on each clock while two enables are high: a global enable and the counter's own enable. A slow mode adds a divide-by-64 prescaler, so the counter then advances once per 64 enabled clocks. A long-overflow mode cancels the slow mode. It also chooses whether the sticky overflow flag tracks a wrap of the low 32-bit field or a wrap of the whole counter.

The counter can be frozen by an external prohibit indication. This happens only while the stop-on-prohibit control is set. Other freeze conditions that apply to event counters do not reach this block, so nothing else stops it.

A one-cycle zero pulse clears the counter and the prescaler. The pulse has no stored state, so it reads back as zero, and it leaves the overflow flag alone. The flag is cleared through its own clear input.

Top module: `cyc_counter`

## Requirements
- R1: With both enables at 1, the prohibit gate open and the slow mode off, count_o increases by exactly 1 on every clock. When the counter passes its full width it wraps to 0.
- R2: While glob_en_i is 0 or cnt_en_i is 0, count_o does not change and the prescaler does not advance.
- R3: With slow_i = 1 and long_ovf_i = 0, count_o increases once per 64 enabled clocks. After the prescaler is cleared, the first increase lands on the 64th enabled clock. Disabled clocks in between are not counted.
- R4: With long_ovf_i = 1, slow_i is ignored and count_o increases on every enabled clock.
- R5: With stop_on_prohibit_i = 1 and prohibit_i = 1, count_o holds. With stop_on_prohibit_i = 0, prohibit_i has no effect.
- R6: With long_ovf_i = 0, ovf_o is set by an increase that wraps the low LO_W bits (32 by default) from all-ones to zero. The carry continues into the upper bits.
- R7: With long_ovf_i = 1, ovf_o is set only when the whole counter wraps from all-ones to zero. A wrap of the low field alone leaves ovf_o unchanged.
- R8: zero_i = 1 sets count_o to 0 and clears the prescaler on the next edge. This overrides an increase in the same cycle and does not depend on long_ovf_i. It leaves ovf_o unchanged.
- R9: ovf_o stays at 1 until a cycle with ovf_clr_i = 1. If an overflow and a clear fall in the same cycle, ovf_o ends at 1.
- R10: While rst_ni is low, count_o is 0 and ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glob_en_i | input | 1 | Global counting enable |
| cnt_en_i | input | 1 | Enable for this counter |
| prohibit_i | input | 1 | Event counting currently prohibited for the lower counter group |
| stop_on_prohibit_i | input | 1 | Freeze the counter while prohibit_i is high |
| slow_i | input | 1 | Advance once per 64 enabled clocks |
| long_ovf_i | input | 1 | Flag on full-width wrap; cancels slow_i |
| zero_i | input | 1 | Pulse: zero the counter and the prescaler |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| count_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A wrong increment, gate or zero decision shows on count_o at the very next edge in the plain and long modes. In slow mode, a prescaler state that is off by any amount moves the next increase away from the 64th enabled clock, so it shows within 64 enabled clocks. A fault in the overflow selection shows only at a wrap point: after 2^LO_W increases for the low field, or after 2^CNT_W increases for the full counter. The bench therefore uses reduced widths to reach both wrap points.

// File: rtl/cyc_counter_pkg.sv
package cyc_counter_pkg;
  localparam int unsigned CNT_W_DEF = 64;
  localparam int unsigned LO_W_DEF  = 32;
  localparam int unsigned PRE_W_DEF = 6;

  typedef enum logic {
    OVF_LOW  = 1'b0,
    OVF_FULL = 1'b1
  } ovf_sel_e;
endpackage

// File: rtl/cyc_gate.sv
module cyc_gate (
  input  logic glob_en_i,
  input  logic cnt_en_i,
  input  logic prohibit_i,
  input  logic stop_on_prohibit_i,
  output logic run_o
);
  logic frozen;

  assign frozen = stop_on_prohibit_i & prohibit_i;
  assign run_o  = glob_en_i & cnt_en_i & ~frozen;
endmodule

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
  parameter int unsigned PRE_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic zero_i,
  input  logic bypass_i,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic             last;

  assign last   = &pre_q;
  assign tick_o = run_i & ~zero_i & (bypass_i | last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (zero_i) pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cyc_count.sv
module cyc_count
  import cyc_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned LO_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             zero_i,
  input  logic             long_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full_top;
  logic             low_top;
  logic             ovf_set;
  ovf_sel_e         sel;

  assign full_top = &cnt_q;

  generate
    if (LO_W >= CNT_W) begin : g_low_is_full
      assign low_top = full_top;
    end else begin : g_low_field
      assign low_top = &cnt_q[LO_W-1:0];
    end
  endgenerate

  assign sel     = long_i ? OVF_FULL : OVF_LOW;
  assign ovf_set = tick_i & ((sel == OVF_FULL) ? full_top : low_top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= (ovf_q & ~clr_i) | ovf_set;
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter
  import cyc_counter_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned LO_W  = LO_W_DEF,
  parameter int unsigned PRE_W = PRE_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glob_en_i,
  input  logic             cnt_en_i,
  input  logic             prohibit_i,
  input  logic             stop_on_prohibit_i,
  input  logic             slow_i,
  input  logic             long_ovf_i,
  input  logic             zero_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic run;
  logic tick;
  logic bypass;

  // long mode cancels the divider
  assign bypass = long_ovf_i | ~slow_i;

  cyc_gate u_gate (
    .glob_en_i          (glob_en_i),
    .cnt_en_i           (cnt_en_i),
    .prohibit_i         (prohibit_i),
    .stop_on_prohibit_i (stop_on_prohibit_i),
    .run_o              (run)
  );

  cyc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .zero_i   (zero_i),
    .bypass_i (bypass),
    .tick_o   (tick)
  );

  cyc_count #(.CNT_W(CNT_W), .LO_W(LO_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .zero_i  (zero_i),
    .long_i  (long_ovf_i),
    .clr_i   (ovf_clr_i),
    .count_o (count_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: rtl/cyc_counter_chk.sv
module cyc_counter_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned LO_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glob_en_i,
  input logic             cnt_en_i,
  input logic             prohibit_i,
  input logic             stop_on_prohibit_i,
  input logic             slow_i,
  input logic             long_ovf_i,
  input logic             zero_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glob_en_i && cnt_en_i && !(stop_on_prohibit_i && prohibit_i) &&
     (long_ovf_i || !slow_i) && !zero_i)
    |=> count_o == CNT_W'($past(count_o) + 1));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(glob_en_i && cnt_en_i) && !zero_i) |=> $stable(count_o));

  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_on_prohibit_i && prohibit_i && !zero_i) |=> $stable(count_o));

  a_r6_low_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_o) && !$past(long_ovf_i)) |-> count_o[LO_W-1:0] == '0);

  a_r7_full_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_o) && $past(long_ovf_i)) |-> count_o == '0);

  a_r8_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> count_o == '0);

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind cyc_counter cyc_counter_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .glob_en_i          (glob_en_i),
  .cnt_en_i           (cnt_en_i),
  .prohibit_i         (prohibit_i),
  .stop_on_prohibit_i (stop_on_prohibit_i),
  .slow_i             (slow_i),
  .long_ovf_i         (long_ovf_i),
  .zero_i             (zero_i),
  .ovf_clr_i          (ovf_clr_i),
  .count_o            (count_o),
  .ovf_o              (ovf_o)
);

// File: tb/cyc_counter_test.sv
`timescale 1ns/1ps
module cyc_counter_test;
  localparam int unsigned CW = 16;
  localparam int unsigned LW = 8;

  typedef struct {
    logic [CW-1:0] cnt;
    logic          ovf;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic glob_en = 1'b0, cnt_en = 1'b0, prohibit = 1'b0, stop_p = 1'b0;
  logic slow = 1'b0, long_ovf = 1'b0, zero = 1'b0, clr = 1'b0;
  logic [CW-1:0] count;
  logic ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  cyc_counter #(.CNT_W(CW), .LO_W(LW), .PRE_W(6)) uut (
    .clk_i              (clk),
    .rst_ni             (rst_ni),
    .glob_en_i          (glob_en),
    .cnt_en_i           (cnt_en),
    .prohibit_i         (prohibit),
    .stop_on_prohibit_i (stop_p),
    .slow_i             (slow),
    .long_ovf_i         (long_ovf),
    .zero_i             (zero),
    .ovf_clr_i          (clr),
    .count_o            (count),
    .ovf_o              (ovf)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input int c, input logic o, input string tag);
    exp_t e;
    e.cnt = c[CW-1:0];
    e.ovf = o;
    e.tag = tag;
    exp_q.push_back(e);
    #2;
  endtask

  task automatic pulse_zero();
    zero = 1'b1; step(1); zero = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pops each expected item and compares it with the outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      #1;
      begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (count !== e.cnt || ovf !== e.ovf) begin
          n_bad++;
          $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
                   e.tag, count, ovf, e.cnt, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    step(3);
    expect_item(0, 1'b0, "R10 reset state");
    rst_ni = 1'b1;

    glob_en = 1'b1; cnt_en = 1'b1;
    step(10);
    expect_item(10, 1'b0, "R1 every clock");

    glob_en = 1'b0; step(5);
    expect_item(10, 1'b0, "R2 global enable low");
    glob_en = 1'b1; cnt_en = 1'b0; step(5);
    expect_item(10, 1'b0, "R2 own enable low");
    cnt_en = 1'b1; step(3);
    expect_item(13, 1'b0, "R1 resumed");

    pulse_zero();
    expect_item(0, 1'b0, "R8 zero beats increment");
    step(2);
    expect_item(2, 1'b0, "R1 after zero");

    // slow mode: zero clears the prescaler too
    slow = 1'b1;
    pulse_zero();
    step(63);
    expect_item(0, 1'b0, "R3 no tick before 64th");
    step(1);
    expect_item(1, 1'b0, "R3 tick on 64th");
    step(30);
    cnt_en = 1'b0; step(10); cnt_en = 1'b1;
    step(33);
    expect_item(1, 1'b0, "R3 disabled clocks not counted");
    step(1);
    expect_item(2, 1'b0, "R3 second tick");

    long_ovf = 1'b1; step(20);
    expect_item(22, 1'b0, "R4 long cancels divider");

    stop_p = 1'b1; prohibit = 1'b1; step(8);
    expect_item(22, 1'b0, "R5 frozen while prohibited");
    stop_p = 1'b0; step(8);
    expect_item(30, 1'b0, "R5 prohibit ignored when gate off");
    prohibit = 1'b0; stop_p = 1'b1; step(4);
    expect_item(34, 1'b0, "R5 gate on, not prohibited");
    stop_p = 1'b0; slow = 1'b0; long_ovf = 1'b0;

    pulse_zero();
    step(255);
    expect_item(255, 1'b0, "R6 before low wrap");
    step(1);
    expect_item(256, 1'b1, "R6 low wrap sets flag, carry kept");
    step(10);
    expect_item(266, 1'b1, "R9 flag sticky");
    pulse_zero();
    expect_item(0, 1'b1, "R8 zero keeps flag");

    glob_en = 1'b0; clr = 1'b1; step(1); clr = 1'b0; glob_en = 1'b1;
    expect_item(0, 1'b0, "R9 clear");
    step(255);
    clr = 1'b1; step(1); clr = 1'b0;
    expect_item(256, 1'b1, "R9 set beats clear");
    glob_en = 1'b0; clr = 1'b1; step(1); clr = 1'b0; glob_en = 1'b1;
    expect_item(256, 1'b0, "R9 clear again");

    long_ovf = 1'b1;
    pulse_zero();
    step(256);
    expect_item(256, 1'b0, "R7 low wrap ignored in long mode");
    step(65279);
    expect_item(65535, 1'b0, "R7 before full wrap");
    step(1);
    expect_item(0, 1'b1, "R7 full wrap sets flag");

    wait (exp_q.size() == 0);
    #3;
    done = 1'b1;
    summary();
  end
endmodule